// File: doc/BRIEF.md
# Status Register and Write Protect Guard

This block keeps the one-byte status word of a serial nonvolatile memory and decides whether each requested array write or status write may start. A command engine presents request strobes in the cycle where the chip select returns high: an array write with its target address, or a status write with its data byte. In that same cycle the block compares the request against four things: the write-enable latch, the busy flag, the block-protect field and the lock bit taken together with the write-protect pin. One cycle later it raises exactly one grant or deny pulse.

After a grant the busy flag stays set until the engine reports that the internal write is finished. The busy flag and the write-enable latch show their live values at all times. The three persistent bits (lock and two protect bits) take their new values only when a granted status write completes, and until then they read back their old values. A synchronous reset stands for power-on and supply-drop detection.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 0x00: lock, protect bits, write-enable latch and busy flag all clear.
- R2: Status layout: bit 7 lock, bits 6..4 always 0, bit 3 and bit 2 the protect field (bit 3 high half), bit 1 write-enable latch, bit 0 busy. A status write loads only bits 7, 3 and 2 from its data; the other data bits have no effect.
- R3: The write-enable latch is set only by the enable strobe and is cleared by the disable strobe, by reset and by completion of any granted write. If a clear and the enable strobe arrive in the same cycle, the clear wins.
- R4: While the write-enable latch is 0, array writes and status writes are refused with a deny pulse and leave the status unchanged.
- R5: Protect field 00 protects nothing, 01 protects the upper quarter of the address space (top two address bits 11), 10 the upper half (top bit 1), and 11 the whole array. An array write to a protected address is denied.
- R6: When lock = 1 and the write-protect pin is low in the request cycle, a status write is denied even with the latch set. With the pin high, status writes follow R4 only.
- R7: During a granted status write, bits 7, 3 and 2 keep their old values. The new values appear in the cycle after the done strobe.
- R8: A granted request produces its grant pulse and sets the busy flag one cycle after the request. The busy flag stays at 1 until the cycle after the done strobe, when it and the write-enable latch both read 0.
- R9: Any write request made while the busy flag is 1 is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on / low-supply reset |
| wprot_n | input | 1 | Write-protect pin, active low |
| addr_i | input | ADDR_W | Target address of an array write |
| wel_set_i | input | 1 | Write-enable command strobe |
| wel_clr_i | input | 1 | Write-disable command strobe |
| arr_req_i | input | 1 | Array write request strobe |
| sr_req_i | input | 1 | Status write request strobe |
| sr_data_i | input | 8 | Data byte of a status write |
| wr_done_i | input | 1 | Internal write finished strobe |
| status_o | output | 8 | Status byte for readback |
| arr_grant_o | output | 1 | Array write accepted (one-cycle pulse) |
| sr_grant_o | output | 1 | Status write accepted (one-cycle pulse) |
| deny_o | output | 1 | Request refused (one-cycle pulse) |

## Verification
A wrong write-enable latch or busy flag shows up on the status byte in the next cycle. It also flips the grant or deny pulse of the very next request, so the bench reads the status after every strobe. A wrong protect decode shows only when an address on the far side of a region edge is requested, so both neighbours of each edge are tried. A commit of the persistent bits too early or too late shows only during a pending status write, so the status is read while the write is busy and again right after the done strobe.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;
  typedef struct packed {
    logic       lock;
    logic [1:0] prot;
  } nv_bits_t;

  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned PHI_BIT  = 3;
  localparam int unsigned PLO_BIT  = 2;

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel, logic wip);
    logic [7:0] s;
    s = 8'h00;
    s[LOCK_BIT] = nv.lock;
    s[PHI_BIT]  = nv.prot[1];
    s[PLO_BIT]  = nv.prot[0];
    s[1]        = wel;
    s[0]        = wip;
    return s;
  endfunction

  function automatic nv_bits_t unpack_nv(logic [7:0] d);
    nv_bits_t n;
    n.lock = d[LOCK_BIT];
    n.prot = {d[PHI_BIT], d[PLO_BIT]};
    return n;
  endfunction
endpackage

// File: rtl/sg_region_decode.sv
module sg_region_decode #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        prot,
  output logic              in_block
);
  localparam int unsigned TOP = ADDR_W - 1;
  localparam int unsigned NXT = ADDR_W - 2;

  always_comb begin
    unique case (prot)
      2'b00:   in_block = 1'b0;
      2'b01:   in_block = addr[TOP] & addr[NXT];
      2'b10:   in_block = addr[TOP];
      default: in_block = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_arbiter.sv
module sg_arbiter (
  input  logic arr_req,
  input  logic sr_req,
  input  logic wel,
  input  logic wip,
  input  logic lock,
  input  logic wprot_n,
  input  logic in_block,
  output logic arr_ok,
  output logic sr_ok,
  output logic deny
);
  logic ready;
  logic hw_lock;

  always_comb begin
    ready   = wel & ~wip;
    hw_lock = lock & ~wprot_n;
    arr_ok  = arr_req & ready & ~in_block;
    sr_ok   = sr_req & ~arr_req & ready & ~hw_lock;
    deny    = (arr_req | sr_req) & ~(arr_ok | sr_ok);
  end
endmodule

// File: rtl/sg_state.sv
module sg_state
  import status_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wel_set,
  input  logic     wel_clr,
  input  logic     arr_ok,
  input  logic     sr_ok,
  input  logic     deny,
  input  nv_bits_t sr_new,
  input  logic     wr_done,
  output nv_bits_t nv_q,
  output logic     wel_q,
  output logic     wip_q,
  output logic     arr_grant_q,
  output logic     sr_grant_q,
  output logic     deny_q
);
  nv_bits_t nv_pend;
  logic     pend_vld;
  logic     finish;

  always_comb finish = wip_q & wr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_q        <= '0;
      nv_pend     <= '0;
      pend_vld    <= 1'b0;
      wel_q       <= 1'b0;
      wip_q       <= 1'b0;
      arr_grant_q <= 1'b0;
      sr_grant_q  <= 1'b0;
      deny_q      <= 1'b0;
    end else begin
      arr_grant_q <= arr_ok;
      sr_grant_q  <= sr_ok;
      deny_q      <= deny;
      if (sr_ok) begin
        nv_pend  <= sr_new;
        pend_vld <= 1'b1;
      end
      if (arr_ok | sr_ok) begin
        wip_q <= 1'b1;
      end else if (finish) begin
        wip_q    <= 1'b0;
        pend_vld <= 1'b0;
        if (pend_vld) nv_q <= nv_pend;
      end
      if (wel_clr | finish) wel_q <= 1'b0;
      else if (wel_set)     wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wprot_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              arr_req_i,
  input  logic              sr_req_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wr_done_i,
  output logic [7:0]        status_o,
  output logic              arr_grant_o,
  output logic              sr_grant_o,
  output logic              deny_o
);
  nv_bits_t nv_q;
  logic     wel_q, wip_q, in_block, arr_ok, sr_ok, deny;

  sg_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .addr     (addr_i),
    .prot     (nv_q.prot),
    .in_block (in_block)
  );

  sg_arbiter u_arb (
    .arr_req  (arr_req_i),
    .sr_req   (sr_req_i),
    .wel      (wel_q),
    .wip      (wip_q),
    .lock     (nv_q.lock),
    .wprot_n  (wprot_n),
    .in_block (in_block),
    .arr_ok   (arr_ok),
    .sr_ok    (sr_ok),
    .deny     (deny)
  );

  sg_state u_state (
    .clk         (clk),
    .rst         (rst),
    .wel_set     (wel_set_i),
    .wel_clr     (wel_clr_i),
    .arr_ok      (arr_ok),
    .sr_ok       (sr_ok),
    .deny        (deny),
    .sr_new      (unpack_nv(sr_data_i)),
    .wr_done     (wr_done_i),
    .nv_q        (nv_q),
    .wel_q       (wel_q),
    .wip_q       (wip_q),
    .arr_grant_q (arr_grant_o),
    .sr_grant_q  (sr_grant_o),
    .deny_q      (deny_o)
  );

  always_comb status_o = pack_status(nv_q, wel_q, wip_q);
endmodule

// File: rtl/status_guard_chk.sv
module status_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wprot_n,
  input logic       wr_done_i,
  input logic [7:0] status_o,
  input logic       arr_grant_o,
  input logic       sr_grant_o,
  input logic       deny_o
);
  // R8
  wip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[0]) |-> (arr_grant_o || sr_grant_o));

  // R8
  wip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[0] && !wr_done_i) |=> status_o[0]);

  // R3
  wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[0]) |-> !status_o[1]);

  // R4
  wel_needed_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_grant_o || sr_grant_o) |-> $past(status_o[1]));

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sr_grant_o |-> !($past(status_o[7]) && !$past(wprot_n)));

  // R7
  nv_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[0] && !wr_done_i) |=> $stable(status_o[7:2]));

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({deny_o, arr_grant_o, sr_grant_o}));
endmodule

bind status_guard status_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wprot_n     (wprot_n),
  .wr_done_i   (wr_done_i),
  .status_o    (status_o),
  .arr_grant_o (arr_grant_o),
  .sr_grant_o  (sr_grant_o),
  .deny_o      (deny_o)
);

// File: tb/test_status_guard.sv
module test_status_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wprot_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          wel_set_i = 1'b0, wel_clr_i = 1'b0;
  logic          arr_req_i = 1'b0, sr_req_i = 1'b0;
  logic [7:0]    sr_data_i = 8'h00;
  logic          wr_done_i = 1'b0;
  logic [7:0]    status_o;
  logic          arr_grant_o, sr_grant_o, deny_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_guard #(.ADDR_W(AW)) i_status_guard (
    .clk(clk), .rst(rst), .wprot_n(wprot_n), .addr_i(addr_i),
    .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
    .arr_req_i(arr_req_i), .sr_req_i(sr_req_i), .sr_data_i(sr_data_i),
    .wr_done_i(wr_done_i), .status_o(status_o),
    .arr_grant_o(arr_grant_o), .sr_grant_o(sr_grant_o), .deny_o(deny_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // answer vector {deny, sr_grant, arr_grant}
  function automatic logic [7:0] ans();
    return {5'b0, deny_o, sr_grant_o, arr_grant_o};
  endfunction

  // drive strobes for one clock edge; on return outputs reflect that edge
  task automatic step(logic set, logic clr, logic areq, logic sreq, logic done);
    @(negedge clk);
    wel_set_i = set; wel_clr_i = clr; arr_req_i = areq; sr_req_i = sreq; wr_done_i = done;
    @(negedge clk);
    wel_set_i = 0; wel_clr_i = 0; arr_req_i = 0; sr_req_i = 0; wr_done_i = 0;
  endtask

  task automatic set_status(logic [7:0] d);
    step(1, 0, 0, 0, 0);
    sr_data_i = d;
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset answers", ans(), 8'h00);
  endtask

  task automatic t_wel();
    step(1, 0, 0, 0, 0);
    chk("R3 enable sets latch", status_o, 8'h02);
    step(0, 1, 0, 0, 0);
    chk("R3 disable clears latch", status_o, 8'h00);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk("R3 clear wins over set", status_o, 8'h00);
  endtask

  task automatic t_no_wel();
    addr_i = 11'h010;
    step(0, 0, 1, 0, 0);
    chk("R4 array write without latch", ans(), 8'h04);
    sr_data_i = 8'h8C;
    step(0, 0, 0, 1, 0);
    chk("R4 status write without latch", ans(), 8'h04);
    chk("R4 status unchanged", status_o, 8'h00);
  endtask

  task automatic t_sr_write();
    step(1, 0, 0, 0, 0);
    sr_data_i = 8'hFF;
    step(0, 0, 0, 1, 0);
    chk("R8 status write granted", ans(), 8'h02);
    chk("R7 old bits during write", status_o, 8'h03);
    step(0, 0, 0, 0, 0);
    chk("R8 busy holds", status_o, 8'h03);
    step(0, 0, 0, 1, 0);
    chk("R9 request while busy", ans(), 8'h04);
    step(0, 0, 0, 0, 1);
    chk("R2 masked bits and commit", status_o, 8'h8C);
  endtask

  task automatic t_hw_lock();
    // status now lock=1, prot=11
    wprot_n = 1'b0;
    step(1, 0, 0, 0, 0);
    sr_data_i = 8'h00;
    step(0, 0, 0, 1, 0);
    chk("R6 locked by pin low", ans(), 8'h04);
    chk("R6 status kept", status_o, 8'h8E);
    wprot_n = 1'b1;
    step(0, 0, 0, 1, 0);
    chk("R6 pin high allows", ans(), 8'h02);
    step(0, 0, 0, 0, 1);
    chk("R6 commit after unlock", status_o, 8'h00);
  endtask

  task automatic t_arr(logic [7:0] sr, logic [AW-1:0] a, logic ok, string req);
    set_status(sr);
    step(1, 0, 0, 0, 0);
    addr_i = a;
    step(0, 0, 1, 0, 0);
    chk(req, ans(), ok ? 8'h01 : 8'h04);
    if (ok) begin
      chk("R8 busy after array grant", status_o[1:0], 8'h03);
      step(0, 0, 0, 0, 1);
      chk("R8 done clears busy and latch", status_o[1:0], 8'h00);
    end else begin
      step(0, 1, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wel();
    t_no_wel();
    t_sr_write();
    t_hw_lock();
    t_arr(8'h00, 11'h7FF, 1'b1, "R5 none protected");
    t_arr(8'h04, 11'h5FF, 1'b1, "R5 quarter below edge");
    t_arr(8'h04, 11'h600, 1'b0, "R5 quarter at edge");
    t_arr(8'h08, 11'h3FF, 1'b1, "R5 half below edge");
    t_arr(8'h08, 11'h400, 1'b0, "R5 half at edge");
    t_arr(8'h0C, 11'h000, 1'b0, "R5 whole array");
    @(negedge clk);
    rst = 1'b1;
    step(1, 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clears protect and latch", status_o, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule